// File: doc/BRIEF.md
# Reloadable Up/Down Counter State Cell

This cell is an 8-bit counter that doubles as a small up/down state machine. The whole cell runs on one fabric clock. It advances only on a count tick, and the tick comes from a selectable source: a base oscillator strobe or one of its power-of-eight divisions, a second oscillator strobe or its divisions, a third oscillator strobe or its divide-by-four, or an external clock pin. The cell synchronizes the external pin and acts on its rising edge. Each tick is registered once before it reaches the counter.

The cell has three control inputs: a count-reset input, a direction input and a hold input. On a reset condition the counter loads a programmable reload value. Four edge or level modes decide what counts as a reset condition. The hold input freezes counting, but a reset condition still acts while hold is high. Direction and hold pass through an optional two-tick synchronizer, which a configuration bit can bypass. A small register port rewrites the reload value at run time. The count is presented in parallel for downstream logic, together with a one-bit flag that marks the zero state.

Top module: `cnt_fsm_cell`

## Requirements
- R1: After synchronous reset, `cnt_value` equals the parameter RELOAD_INIT (default 6), `cnt_out` is 0 and the reload register holds RELOAD_INIT.
- R2: `cnt_value` and `cnt_out` change only on the fabric clock edge that follows a clock edge where the selected source produced a tick. With `cfg_clk_sel` = 14 or 15, no tick is produced and the count stays frozen.
- R3: `cfg_clk_sel` encoding:
  - 0 is every `osc0_tick`.
  - 1 to 6 are every 8th, 64th, 512th, 4096th, 32768th and 262144th `osc0_tick`, counted from reset.
  - 7 is every `osc1_tick`, and 8 to 10 are every 8th, 64th and 512th `osc1_tick`.
  - 11 is every `osc2_tick`, and 12 is every 4th `osc2_tick`.
- R4: On a tick with no reset condition, hold inactive and effective direction 1 (up), the count increments by one, wrapping from 255 to 0.
- R5: On a tick with no reset condition, hold inactive and effective direction 0 (down), the count decrements by one. From 0 it loads the reload value instead.
- R6: `cnt_out` is 1 exactly while `cnt_value` is 0.
- R7: `cfg_rst_mode` selects the reset condition on each tick, comparing `cnt_rst_in` with its value at the previous tick:
  - 0 is a rise.
  - 1 is a fall.
  - 2 is any change.
  - 3 is `cnt_rst_in` high.
- R8: In mode 3, the count stays at the reload value for every tick on which `cnt_rst_in` is high.
- R9: While the effective hold is 1 and no reset condition occurs, ticks leave the count unchanged, whatever the direction input does.
- R10: A reset condition loads the reload value even when the effective hold is 1.
- R11: With `cfg_sync_bypass` = 0, the direction and hold values used on a tick are those sampled two ticks earlier. With `cfg_sync_bypass` = 1, the current inputs are used.
- R12: A clock with `reg_we` = 1 and nonzero `reg_wdata` sets the reload value used by later reloads. A write of 0 is ignored.
- R13: With `cfg_clk_sel` = 13, each rising edge of `ext_clk` produces one tick, after a two-flop synchronizer and an edge detector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| osc0_tick | input | 1 | Base oscillator strobe, one clock wide |
| osc1_tick | input | 1 | Second oscillator strobe |
| osc2_tick | input | 1 | Third oscillator strobe |
| ext_clk | input | 1 | External clock, asynchronous |
| cnt_rst_in | input | 1 | Count-reset input |
| dir_up_in | input | 1 | Direction: 1 counts up, 0 counts down |
| hold_in | input | 1 | Hold: 1 freezes counting |
| cfg_clk_sel | input | 4 | Tick source select (R3, R13) |
| cfg_rst_mode | input | 2 | Reset condition mode (R7) |
| cfg_sync_bypass | input | 1 | 1 bypasses the direction/hold synchronizer |
| reg_we | input | 1 | Reload register write strobe |
| reg_wdata | input | 8 | Reload write data |
| cnt_out | output | 1 | Zero flag |
| cnt_value | output | 8 | Parallel count |

## Verification
The assertions assume that the oscillator strobes, the control inputs and the register port are driven synchronously to `clk`, with only `ext_clk` arriving freely. They also assume that the reload register never holds 0, so a reload cannot be mistaken for a wrap. The stimulus changes every input just after the falling edge, writes only legal reload values apart from the deliberate zero write, and brings in `ext_clk` as a slow square wave so that each rise survives the synchronizer.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
  localparam int CLK_SEL_W = 4;

  typedef enum logic [1:0] {
    RM_RISE  = 2'd0,
    RM_FALL  = 2'd1,
    RM_BOTH  = 2'd2,
    RM_LEVEL = 2'd3
  } rst_mode_e;
endpackage

// File: rtl/cfc_tick_gen.sv
module cfc_tick_gen #(
  parameter int DIV_LOG     = 3,
  parameter int DIV0_STAGES = 6,
  parameter int DIV1_STAGES = 3,
  parameter int DIV2_LOG    = 2,
  parameter int SEL_W       = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             osc0_tick,
  input  logic             osc1_tick,
  input  logic             osc2_tick,
  input  logic             ext_clk,
  input  logic [SEL_W-1:0] clk_sel,
  output logic             tick_q
);
  localparam int W0   = DIV_LOG * DIV0_STAGES;
  localparam int W1   = DIV_LOG * DIV1_STAGES;
  localparam int NSRC = (DIV0_STAGES + 1) + (DIV1_STAGES + 1) + 2 + 1;

  logic [W0-1:0]        div0_q;
  logic [W1-1:0]        div1_q;
  logic [DIV2_LOG-1:0]  div2_q;
  logic [DIV0_STAGES:0] t0;
  logic [DIV1_STAGES:0] t1;
  logic [1:0]           t2;
  logic                 ext_m, ext_s, ext_p, ext_rise;
  logic [NSRC-1:0]      all_ticks;
  logic                 sel_tick;

  always_ff @(posedge clk) begin
    if (rst) begin
      div0_q <= '0;
      div1_q <= '0;
      div2_q <= '0;
    end else begin
      if (osc0_tick) div0_q <= div0_q + 1'b1;
      if (osc1_tick) div1_q <= div1_q + 1'b1;
      if (osc2_tick) div2_q <= div2_q + 1'b1;
    end
  end

  assign t0[0] = osc0_tick;
  assign t1[0] = osc1_tick;

  generate
    for (genvar k = 1; k <= DIV0_STAGES; k++) begin : g_div0
      assign t0[k] = osc0_tick & (&div0_q[DIV_LOG*k-1:0]);
    end
    for (genvar k = 1; k <= DIV1_STAGES; k++) begin : g_div1
      assign t1[k] = osc1_tick & (&div1_q[DIV_LOG*k-1:0]);
    end
  endgenerate

  assign t2[0] = osc2_tick;
  assign t2[1] = osc2_tick & (&div2_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_m <= 1'b0;
      ext_s <= 1'b0;
      ext_p <= 1'b0;
    end else begin
      ext_m <= ext_clk;
      ext_s <= ext_m;
      ext_p <= ext_s;
    end
  end

  assign ext_rise  = ext_s & ~ext_p;
  assign all_ticks = {ext_rise, t2, t1, t0};

  always_comb begin
    sel_tick = 1'b0;
    if (int'(clk_sel) < NSRC) sel_tick = all_ticks[clk_sel];
  end

  always_ff @(posedge clk) begin
    if (rst) tick_q <= 1'b0;
    else     tick_q <= sel_tick;
  end
endmodule

// File: rtl/cfc_in_sync.sv
module cfc_in_sync #(
  parameter int W     = 2,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         bypass,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          stg[i] <= '0;
        end else if (tick) begin
          if (i == 0) stg[i] <= d;
          else        stg[i] <= stg[(i == 0) ? 0 : i-1];
        end
      end
    end
  endgenerate

  assign q = bypass ? d : stg[DEPTH-1];
endmodule

// File: rtl/cfc_rst_detect.sv
module cfc_rst_detect
  import cfc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      rst_in,
  input  rst_mode_e mode,
  output logic      rst_cond
);
  logic last_q;

  always_ff @(posedge clk) begin
    if (rst)       last_q <= 1'b0;
    else if (tick) last_q <= rst_in;
  end

  always_comb begin
    unique case (mode)
      RM_RISE:  rst_cond = rst_in & ~last_q;
      RM_FALL:  rst_cond = ~rst_in & last_q;
      RM_BOTH:  rst_cond = rst_in ^ last_q;
      default:  rst_cond = rst_in;
    endcase
  end
endmodule

// File: rtl/cfc_core.sv
module cfc_core #(
  parameter int               CNT_W       = 8,
  parameter logic [CNT_W-1:0] RELOAD_INIT = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             rst_cond,
  input  logic             hold_eff,
  input  logic             up_eff,
  input  logic             reg_we,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reload_o,
  output logic [CNT_W-1:0] count_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] reload_q, count_q, count_nxt;
  logic             zero_q;

  always_ff @(posedge clk) begin
    if (rst)                      reload_q <= RELOAD_INIT;
    else if (reg_we && |reg_wdata) reload_q <= reg_wdata;
  end

  always_comb begin
    count_nxt = count_q;
    if (rst_cond)            count_nxt = reload_q;
    else if (!hold_eff) begin
      if (up_eff)            count_nxt = count_q + 1'b1;
      else if (count_q == '0) count_nxt = reload_q;
      else                   count_nxt = count_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= RELOAD_INIT;
      zero_q  <= 1'b0;
    end else if (tick) begin
      count_q <= count_nxt;
      zero_q  <= (count_nxt == '0);
    end
  end

  assign reload_o = reload_q;
  assign count_o  = count_q;
  assign zero_o   = zero_q;
endmodule

// File: rtl/cnt_fsm_cell.sv
module cnt_fsm_cell
  import cfc_pkg::*;
#(
  parameter int               CNT_W       = 8,
  parameter logic [CNT_W-1:0] RELOAD_INIT = 6,
  parameter int               SYNC_DEPTH  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 osc0_tick,
  input  logic                 osc1_tick,
  input  logic                 osc2_tick,
  input  logic                 ext_clk,
  input  logic                 cnt_rst_in,
  input  logic                 dir_up_in,
  input  logic                 hold_in,
  input  logic [CLK_SEL_W-1:0] cfg_clk_sel,
  input  logic [1:0]           cfg_rst_mode,
  input  logic                 cfg_sync_bypass,
  input  logic                 reg_we,
  input  logic [CNT_W-1:0]     reg_wdata,
  output logic                 cnt_out,
  output logic [CNT_W-1:0]     cnt_value
);
  logic             tick_q;
  logic             rst_cond;
  logic             hold_eff, up_eff;
  logic [CNT_W-1:0] reload_val;

  cfc_tick_gen #(.SEL_W(CLK_SEL_W)) u_tick (
    .clk(clk), .rst(rst),
    .osc0_tick(osc0_tick), .osc1_tick(osc1_tick), .osc2_tick(osc2_tick),
    .ext_clk(ext_clk), .clk_sel(cfg_clk_sel), .tick_q(tick_q)
  );

  cfc_in_sync #(.W(2), .DEPTH(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst(rst), .tick(tick_q), .bypass(cfg_sync_bypass),
    .d({hold_in, dir_up_in}), .q({hold_eff, up_eff})
  );

  cfc_rst_detect u_rdet (
    .clk(clk), .rst(rst), .tick(tick_q), .rst_in(cnt_rst_in),
    .mode(rst_mode_e'(cfg_rst_mode)), .rst_cond(rst_cond)
  );

  cfc_core #(.CNT_W(CNT_W), .RELOAD_INIT(RELOAD_INIT)) u_core (
    .clk(clk), .rst(rst), .tick(tick_q), .rst_cond(rst_cond),
    .hold_eff(hold_eff), .up_eff(up_eff),
    .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reload_o(reload_val), .count_o(cnt_value), .zero_o(cnt_out)
  );
endmodule

// File: rtl/cnt_fsm_cell_chk.sv
module cnt_fsm_cell_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             rst_cond,
  input logic             hold_eff,
  input logic             up_eff,
  input logic [CNT_W-1:0] reload,
  input logic             reg_we,
  input logic [CNT_W-1:0] reg_wdata,
  input logic             cnt_out,
  input logic [CNT_W-1:0] cnt_value
);
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt_value)); // R2

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    cnt_out == (cnt_value == '0)); // R6

  AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
    tick && !rst_cond && !hold_eff && up_eff |=> cnt_value == CNT_W'($past(cnt_value) + 1'b1)); // R4

  AST_DOWN_RELOAD: assert property (@(posedge clk) disable iff (rst)
    tick && !rst_cond && !hold_eff && !up_eff && cnt_value == '0 |=> cnt_value == $past(reload)); // R5

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (rst)
    tick && hold_eff && !rst_cond |=> $stable(cnt_value)); // R9

  AST_RST_WINS: assert property (@(posedge clk) disable iff (rst)
    tick && rst_cond |=> cnt_value == $past(reload)); // R10

  AST_ZERO_WRITE: assert property (@(posedge clk) disable iff (rst)
    reg_we && reg_wdata == '0 |=> $stable(reload)); // R12
endmodule

bind cnt_fsm_cell cnt_fsm_cell_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick_q), .rst_cond(rst_cond),
  .hold_eff(hold_eff), .up_eff(up_eff), .reload(reload_val),
  .reg_we(reg_we), .reg_wdata(reg_wdata),
  .cnt_out(cnt_out), .cnt_value(cnt_value)
);

// File: tb/cnt_fsm_cell_bench.sv
module cnt_fsm_cell_bench;
  localparam int CLK_PERIOD = 10;
  localparam int INIT = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       osc0_tick = 1'b1, osc1_tick = 1'b0, osc2_tick = 1'b0, ext_clk = 1'b0;
  logic       cnt_rst_in = 1'b0, dir_up_in = 1'b1, hold_in = 1'b0;
  logic [3:0] cfg_clk_sel = 4'd0;
  logic [1:0] cfg_rst_mode = 2'd0;
  logic       cfg_sync_bypass = 1'b1;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'd0;
  logic       cnt_out;
  logic [7:0] cnt_value;

  int    checks = 0, fails = 0;
  bit    done = 0;
  string cur_req = "R1";

  // reference model state
  int m_count, m_out, m_reload, m_tick, c0, c1, c2, e1, e2, e3, r_last;
  int dq[$], hq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cnt_fsm_cell u_cnt_fsm_cell (
    .clk(clk), .rst(rst), .osc0_tick(osc0_tick), .osc1_tick(osc1_tick),
    .osc2_tick(osc2_tick), .ext_clk(ext_clk), .cnt_rst_in(cnt_rst_in),
    .dir_up_in(dir_up_in), .hold_in(hold_in), .cfg_clk_sel(cfg_clk_sel),
    .cfg_rst_mode(cfg_rst_mode), .cfg_sync_bypass(cfg_sync_bypass),
    .reg_we(reg_we), .reg_wdata(reg_wdata),
    .cnt_out(cnt_out), .cnt_value(cnt_value)
  );

  function automatic int pow8(int k);
    int v = 1;
    for (int i = 0; i < k; i++) v = v * 8;
    return v;
  endfunction

  always @(posedge clk) begin
    int sel_t, up, hd, rc, n, s;
    if (rst) begin
      m_count = INIT; m_out = 0; m_reload = INIT; m_tick = 0;
      c0 = 0; c1 = 0; c2 = 0; e1 = 0; e2 = 0; e3 = 0; r_last = 0;
      dq = '{0, 0}; hq = '{0, 0};
    end else begin
      s = int'(cfg_clk_sel);
      sel_t = 0;
      if (s == 0) sel_t = osc0_tick;
      else if (s <= 6) sel_t = osc0_tick && (c0 % pow8(s)) == pow8(s) - 1;
      else if (s == 7) sel_t = osc1_tick;
      else if (s <= 10) sel_t = osc1_tick && (c1 % pow8(s-7)) == pow8(s-7) - 1;
      else if (s == 11) sel_t = osc2_tick;
      else if (s == 12) sel_t = osc2_tick && (c2 % 4) == 3;
      else if (s == 13) sel_t = (e2 == 1 && e3 == 0);
      if (m_tick != 0) begin
        up = cfg_sync_bypass ? int'(dir_up_in) : dq[0];
        hd = cfg_sync_bypass ? int'(hold_in) : hq[0];
        case (cfg_rst_mode)
          2'd0: rc = (cnt_rst_in && r_last == 0);
          2'd1: rc = (!cnt_rst_in && r_last == 1);
          2'd2: rc = (int'(cnt_rst_in) != r_last);
          default: rc = cnt_rst_in;
        endcase
        if (rc != 0) n = m_reload;
        else if (hd != 0) n = m_count;
        else if (up != 0) n = (m_count + 1) % 256;
        else n = (m_count == 0) ? m_reload : m_count - 1;
        m_count = n; m_out = (n == 0);
        dq.push_back(int'(dir_up_in)); void'(dq.pop_front());
        hq.push_back(int'(hold_in));   void'(hq.pop_front());
        r_last = cnt_rst_in;
      end
      if (reg_we && reg_wdata != 0) m_reload = reg_wdata;
      if (osc0_tick) c0 = (c0 + 1) % 262144;
      if (osc1_tick) c1 = (c1 + 1) % 512;
      if (osc2_tick) c2 = (c2 + 1) % 4;
      e3 = e2; e2 = e1; e1 = ext_clk;
      m_tick = sel_t;
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      checks++;
      if (int'(cnt_value) !== m_count || int'(cnt_out) !== m_out) begin
        fails++;
        $display("FAIL %s: count=%0d out=%0d expected count=%0d out=%0d",
                 cur_req, cnt_value, cnt_out, m_count, m_out);
      end
    end
  endtask

  task automatic pulse_rst(int len);
    cnt_rst_in = 1'b1; step(len);
    cnt_rst_in = 1'b0; step(6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state against fixed values
    checks++;
    if (cnt_value !== 8'(INIT) || cnt_out !== 1'b0) begin
      fails++;
      $display("FAIL R1: count=%0d out=%0d expected count=%0d out=0", cnt_value, cnt_out, INIT);
    end
    cur_req = "R4"; dir_up_in = 1'b1; step(265);
    cur_req = "R5"; dir_up_in = 1'b0; step(20);
    cur_req = "R6"; step(12);
    cur_req = "R11";
    cfg_sync_bypass = 1'b0;
    for (int i = 0; i < 6; i++) begin dir_up_in = ~dir_up_in; step(3); end
    hold_in = 1'b1; step(4); hold_in = 1'b0; step(4);
    cfg_sync_bypass = 1'b1; step(4);
    cur_req = "R9"; hold_in = 1'b1;
    for (int i = 0; i < 5; i++) begin dir_up_in = ~dir_up_in; step(2); end
    cur_req = "R10"; cfg_rst_mode = 2'd0; pulse_rst(2);
    hold_in = 1'b0; dir_up_in = 1'b1; step(5);
    cur_req = "R7";
    for (int m = 0; m < 3; m++) begin
      cfg_rst_mode = 2'(m); step(3); pulse_rst(3);
    end
    cur_req = "R8"; cfg_rst_mode = 2'd3; dir_up_in = 1'b0; pulse_rst(10);
    cfg_rst_mode = 2'd0; step(3);
    cur_req = "R12";
    reg_we = 1'b1; reg_wdata = 8'd0; step(1); reg_we = 1'b0; step(2);
    pulse_rst(1);
    reg_we = 1'b1; reg_wdata = 8'd40; step(1); reg_we = 1'b0; step(2);
    pulse_rst(1); step(45);
    cur_req = "R3"; dir_up_in = 1'b1;
    cfg_clk_sel = 4'd1; step(80);
    cfg_clk_sel = 4'd2; step(200);
    cfg_clk_sel = 4'd8;
    for (int i = 0; i < 60; i++) begin osc1_tick = (i % 3 == 0); step(1); end
    cfg_clk_sel = 4'd7;
    for (int i = 0; i < 20; i++) begin osc1_tick = (i % 2 == 0); step(1); end
    osc1_tick = 1'b0;
    cfg_clk_sel = 4'd12;
    for (int i = 0; i < 40; i++) begin osc2_tick = (i % 2 == 1); step(1); end
    cfg_clk_sel = 4'd11;
    for (int i = 0; i < 10; i++) begin osc2_tick = (i % 3 == 0); step(1); end
    osc2_tick = 1'b0;
    cur_req = "R2"; cfg_clk_sel = 4'd14; pulse_rst(2); step(10);
    cfg_clk_sel = 4'd15; step(10);
    cur_req = "R13"; cfg_clk_sel = 4'd13;
    for (int i = 0; i < 80; i++) begin ext_clk = ((i / 5) % 2 == 1); step(1); end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule